// File: doc/BRIEF.md
# Single-Wire RGB Pixel Serializer

This block drives a daisy chain of smart RGB LEDs over one data wire. Pixels come in on a valid/ready stream as separate 8-bit green, red and blue fields. A frame length travels alongside the first pixel of each frame. Every pixel becomes 24 pulse-width coded bits. A bit is a high pulse followed by a low gap, and the lengths of the two phases carry the bit value. The nominal bit period is about 1.25 µs, which is roughly 800 kHz.

When the last pixel of a frame has been sent, the line stays low for the latch interval of about 50 µs, so the LEDs can take over their data. All durations are derived in clock cycles from the `CLK_HZ` parameter. The upstream source can pause between pixels. If it pauses for as long as the latch interval, the chain will already have latched a partial frame, and the block raises a flag to report it.

Top module: `pixel_wire_tx`

## Requirements
- R1: The bits of each pixel go out in this order: the green byte, then red, then blue, each byte starting at bit 7.
- R2: A 0 bit is a high of T0H cycles followed by a low of T0L cycles. Each value is round(CLK_HZ·t) with at least 1, for 400 ns and 850 ns.
- R3: A 1 bit is a high of T1H cycles followed by a low of T1L cycles, for 850 ns and 450 ns, rounded the same way. Inside one pixel the bits follow each other with no gap.
- R4: After reset the line is low and `busy` is low. `busy` goes high in the cycle after the first pixel of a frame is accepted. Whenever `busy` is low, the line is low.
- R5: After the last bit of a frame, the line stays low while `busy` stays high. `busy` falls exactly (low time of that last bit) + LATCH cycles after the final falling edge, where LATCH = round(CLK_HZ·50 µs).
- R6: `s_ready` is low while a pixel is being shifted out and during the latch interval. It is high when idle and while waiting for the next pixel of a frame.
- R7: `frame_len` is sampled together with the first pixel of a frame, and the frame ends after that many pixels. A `frame_len` of 0 counts as 1.
- R8: While waiting for a pixel in the middle of a frame, the line stays low. If LATCH consecutive cycles pass in that wait with no pixel accepted, `underrun` goes to 1. It holds until the first pixel of the next frame is accepted. A shorter pause leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Pixel stream valid |
| s_ready | output | 1 | Pixel stream ready |
| s_green | input | 8 | Green component |
| s_red | input | 8 | Red component |
| s_blue | input | 8 | Blue component |
| frame_len | input | LEN_W | Pixels in the frame, sampled with the first pixel |
| line_out | output | 1 | Serial LED data line |
| busy | output | 1 | Frame in progress, including the latch interval |
| underrun | output | 1 | Mid-frame stall reached the latch interval |

## Verification
The assertions take for granted that the stream follows the handshake:
- a pixel and its `frame_len` stay stable from the time `s_valid` rises until the transfer happens;
- `frame_len` never exceeds `MAX_PIXELS`;
- inputs are known once reset is released.

The driver keeps within these rules. It changes inputs only on the falling clock edge and holds `s_valid` and the data until it sees `s_ready`. Frame lengths are 0 to 3, and stalls are placed only after the previous pixel has fully left the line, so that the waiting state is really entered.

// File: rtl/pwtx_pkg.sv
// Shared types and timing helpers for the single-wire pixel serializer.
// Assumes durations are given in nanoseconds and the clock in hertz.
package pwtx_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_LATCH} tx_state_e;
    typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} bit_phase_e;

    // Nearest whole number of clock cycles for a duration, never below one.
    function automatic int ns_to_cycles(input longint clk_hz, input longint dur_ns);
        longint c;
        c = (clk_hz * dur_ns + 64'd500_000_000) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwtx_bit_gen.sv
// One-bit pulse generator: on start_i, drives a high phase followed by a low
// phase. The lengths of both phases depend on bit_i. done_o marks the last
// low cycle, and a start in that same cycle chains the next bit with no gap.
// Assumes start_i is asserted only when idle or when done_o is high.
module pwtx_bit_gen
    import pwtx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T0H   = 8,
    parameter int T0L   = 17,
    parameter int T1H   = 17,
    parameter int T1L   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bit_i,
    output logic line_o,
    output logic done_o
);
    localparam logic [CNT_W-1:0] H0_LD = CNT_W'(T0H - 1);
    localparam logic [CNT_W-1:0] L0_LD = CNT_W'(T0L - 1);
    localparam logic [CNT_W-1:0] H1_LD = CNT_W'(T1H - 1);
    localparam logic [CNT_W-1:0] L1_LD = CNT_W'(T1L - 1);

    bit_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic             cur_bit;

    assign done_o = (phase == PH_LOW) && (cnt == '0);
    assign line_o = (phase == PH_HIGH);

    // Phase sequencing and down-counting of the high and low durations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            cur_bit <= 1'b0;
        end else if (start_i) begin
            phase   <= PH_HIGH;
            cnt     <= bit_i ? H1_LD : H0_LD;
            cur_bit <= bit_i;
        end else if (phase == PH_HIGH && cnt == '0) begin
            phase <= PH_LOW;
            cnt   <= cur_bit ? L1_LD : L0_LD;
        end else if (done_o) begin
            phase <= PH_IDLE;
        end else if (phase != PH_IDLE) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R3: the controller never restarts a bit that is still in progress.
    a_r3_start_legal: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (phase == PH_IDLE || done_o));

endmodule

// File: rtl/pwtx_frame_ctrl.sv
// Frame controller: accepts pixels, shifts out their 24 bits in green, red,
// blue order with the most significant bit first, counts pixels in the frame,
// times the latch gap and flags mid-frame stalls.
// Assumes frame_len is stable with the first pixel of a frame.
module pwtx_frame_ctrl
    import pwtx_pkg::*;
#(
    parameter int LEN_W     = 5,
    parameter int CNT_W     = 13,
    parameter int LATCH_CYC = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_green,
    input  logic [7:0]       s_red,
    input  logic [7:0]       s_blue,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             bit_done_i,
    input  logic             line_i,
    output logic             start_o,
    output logic             bit_o,
    output logic             busy_o,
    output logic             underrun_o
);
    localparam logic [CNT_W-1:0] LATCH_LD = CNT_W'(LATCH_CYC - 1);
    localparam logic [4:0]       LAST_IDX = 5'd23;

    tx_state_e        state;
    logic [22:0]      shreg;
    logic [4:0]       bit_idx;
    logic [LEN_W-1:0] pix_left;
    logic [CNT_W-1:0] tcnt;
    logic             accept;
    logic             more_bits;

    assign s_ready   = (state == ST_IDLE) || (state == ST_WAIT);
    assign accept    = s_valid && s_ready;
    assign more_bits = bit_done_i && (bit_idx != '0);
    assign start_o   = accept || more_bits;
    assign bit_o     = accept ? s_green[7] : shreg[22];
    assign busy_o    = (state != ST_IDLE);

    // Frame sequencing, bit shifting, latch timing and stall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bit_idx    <= '0;
            pix_left   <= '0;
            tcnt       <= '0;
            underrun_o <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state      <= ST_SEND;
                    shreg      <= {s_green[6:0], s_red, s_blue};
                    bit_idx    <= LAST_IDX;
                    pix_left   <= (frame_len == '0) ? '0 : frame_len - 1'b1;
                    underrun_o <= 1'b0;
                end
                ST_WAIT: if (accept) begin
                    state    <= ST_SEND;
                    shreg    <= {s_green[6:0], s_red, s_blue};
                    bit_idx  <= LAST_IDX;
                    pix_left <= pix_left - 1'b1;
                    tcnt     <= '0;
                end else if (tcnt == LATCH_LD) begin
                    underrun_o <= 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
                ST_SEND: if (bit_done_i) begin
                    if (bit_idx != '0) begin
                        shreg   <= shreg << 1;
                        bit_idx <= bit_idx - 1'b1;
                    end else if (pix_left == '0) begin
                        state <= ST_LATCH;
                        tcnt  <= LATCH_LD;
                    end else begin
                        state <= ST_WAIT;
                        tcnt  <= '0;
                    end
                end
                default: if (tcnt == '0) begin
                    state <= ST_IDLE;
                end else begin
                    tcnt <= tcnt - 1'b1;
                end
            endcase
        end
    end

    // R6: no new pixel is offered while the line carries a pulse.
    a_r6_ready_low_sending: assert property (@(posedge clk) disable iff (!rst_n)
        line_i |-> !s_ready);

    // R5: the line stays low through the latch interval.
    a_r5_latch_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH) |-> !line_i);

    // R8: an underrun can only be raised inside an open frame.
    a_r8_underrun_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> busy_o);

endmodule

// File: rtl/pixel_wire_tx.sv
// Top of the single-wire pixel serializer. Derives all cycle counts from
// CLK_HZ and connects the frame controller to the bit pulse generator.
// Assumes the stream obeys valid/ready and frame_len <= MAX_PIXELS.
module pixel_wire_tx
    import pwtx_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int MAX_PIXELS = 24,
    parameter int T0H_NS     = 400,
    parameter int T0L_NS     = 850,
    parameter int T1H_NS     = 850,
    parameter int T1L_NS     = 450,
    parameter int LATCH_NS   = 50_000,
    parameter int LEN_W      = $clog2(MAX_PIXELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_green,
    input  logic [7:0]       s_red,
    input  logic [7:0]       s_blue,
    input  logic [LEN_W-1:0] frame_len,
    output logic             line_out,
    output logic             busy,
    output logic             underrun
);
    localparam int T0H_C   = ns_to_cycles(CLK_HZ, T0H_NS);
    localparam int T0L_C   = ns_to_cycles(CLK_HZ, T0L_NS);
    localparam int T1H_C   = ns_to_cycles(CLK_HZ, T1H_NS);
    localparam int T1L_C   = ns_to_cycles(CLK_HZ, T1L_NS);
    localparam int LATCH_C = ns_to_cycles(CLK_HZ, LATCH_NS);
    localparam int MAX_C   = max2(max2(max2(T0H_C, T0L_C), max2(T1H_C, T1L_C)), LATCH_C);
    localparam int CNT_W   = $clog2(MAX_C + 1);

    logic start;
    logic bit_val;
    logic bit_done;

    pwtx_frame_ctrl #(
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W),
        .LATCH_CYC (LATCH_C)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_green    (s_green),
        .s_red      (s_red),
        .s_blue     (s_blue),
        .frame_len  (frame_len),
        .bit_done_i (bit_done),
        .line_i     (line_out),
        .start_o    (start),
        .bit_o      (bit_val),
        .busy_o     (busy),
        .underrun_o (underrun)
    );

    pwtx_bit_gen #(
        .CNT_W (CNT_W),
        .T0H   (T0H_C),
        .T0L   (T0L_C),
        .T1H   (T1H_C),
        .T1L   (T1L_C)
    ) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .bit_i   (bit_val),
        .line_o  (line_out),
        .done_o  (bit_done)
    );

    // R4: an idle block keeps the wire low.
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_out);

endmodule

// File: tb/pixel_wire_tx_tb.sv
// Scoreboard bench: the driver queues the expected bits of each pixel, and
// the monitor measures the pulses on the wire and compares them.
module pixel_wire_tx_tb;
    localparam int CLK_HZ = 20_000_000;
    localparam int LEN_W  = 5;
    // Cycle counts worked out from the requirements at 20 MHz.
    localparam int C0H  = 8;
    localparam int C0L  = 17;
    localparam int C1H  = 17;
    localparam int C1L  = 9;
    localparam int CLAT = 1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [7:0]       s_green = '0, s_red = '0, s_blue = '0;
    logic [LEN_W-1:0] frame_len = '0;
    logic             line_out, busy, underrun;

    int total = 0;
    int bad = 0;
    bit exp_q[$];
    bit last_sent = 1'b0;
    int frames_done = 0;

    always #5 clk = ~clk;

    pixel_wire_tx #(.CLK_HZ(CLK_HZ), .MAX_PIXELS(24)) u_dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_green(s_green), .s_red(s_red), .s_blue(s_blue),
        .frame_len(frame_len), .line_out(line_out), .busy(busy),
        .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures highs and lows, pops expected bits, checks the latch gap.
    bit prev_line = 1'b0, prev_busy = 1'b0, last_bit = 1'b0, have_bit = 1'b0;
    int hi_run = 0, lo_run = 0, mon_bits = 0, bit_no = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_line = 1'b0; prev_busy = 1'b0; have_bit = 1'b0;
            hi_run = 0; lo_run = 0; mon_bits = 0;
        end else begin
            if (line_out) begin
                if (!prev_line) begin
                    if (have_bit) begin
                        if (bit_no != 23)
                            check(lo_run == (last_bit ? C1L : C0L), last_bit ? "R3 low" : "R2 low",
                                  lo_run, last_bit ? C1L : C0L);
                        else
                            check(lo_run >= (last_bit ? C1L : C0L), "R1 pixel gap low",
                                  lo_run, last_bit ? C1L : C0L);
                    end
                    hi_run = 0;
                end
                hi_run++;
                lo_run = 0;
                check(!s_ready, "R6 ready while sending", s_ready, 0);
            end else begin
                if (prev_line) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1 unexpected bit", hi_run, 0);
                    end else begin
                        last_bit = exp_q.pop_front();
                        check(hi_run == (last_bit ? C1H : C0H), last_bit ? "R3 high" : "R2 high",
                              hi_run, last_bit ? C1H : C0H);
                        have_bit = 1'b1;
                        bit_no = mon_bits % 24;
                        mon_bits++;
                    end
                    lo_run = 1;
                end else if (busy) begin
                    lo_run++;
                end
                if (busy && last_sent && exp_q.size() == 0 && lo_run > (last_bit ? C1L : C0L))
                    check(!s_ready, "R6 ready in latch", s_ready, 0);
            end
            if (!busy)
                check(!line_out, "R4 idle line low", line_out, 0);
            if (prev_busy && !busy) begin
                check(lo_run == (last_bit ? C1L : C0L) + CLAT, "R5 latch gap",
                      lo_run, (last_bit ? C1L : C0L) + CLAT);
                frames_done++;
            end
            prev_line = line_out;
            prev_busy = busy;
        end
    end

    // Driver: offers one pixel, queues its expected bits once it is accepted.
    task automatic send_pixel(input logic [7:0] g, input logic [7:0] r, input logic [7:0] b,
                              input int len, input bit last, input bit first);
        @(negedge clk);
        s_valid = 1'b1; s_green = g; s_red = r; s_blue = b; frame_len = LEN_W'(len);
        while (!s_ready) @(negedge clk);
        for (int i = 7; i >= 0; i--) exp_q.push_back(g[i]);
        for (int i = 7; i >= 0; i--) exp_q.push_back(r[i]);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
        last_sent = last;
        @(negedge clk);
        s_valid = 1'b0;
        if (first) check(busy == 1'b1, "R4 busy after first pixel", busy, 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out == 1'b0, "R4 reset line", line_out, 0);
        check(busy == 1'b0, "R4 reset busy", busy, 0);
        check(s_ready == 1'b1, "R6 reset ready", s_ready, 1);
        check(underrun == 1'b0, "R8 reset underrun", underrun, 0);

        // R1 R2 R3: single pixel with mixed bits
        send_pixel(8'hFF, 8'h00, 8'hA5, 1, 1'b1, 1'b1);
        wait_idle();
        check(frames_done == 1, "R7 frame count", frames_done, 1);

        // R1 R7: three pixels back to back
        send_pixel(8'h12, 8'h34, 8'h56, 3, 1'b0, 1'b1);
        send_pixel(8'h80, 8'h01, 8'h7E, 3, 1'b0, 1'b0);
        send_pixel(8'h00, 8'hFF, 8'hC3, 3, 1'b1, 1'b0);
        wait_idle();
        check(frames_done == 2, "R7 three-pixel frame", frames_done, 2);
        check(exp_q.size() == 0, "R1 all bits sent", exp_q.size(), 0);

        // R7: a length of zero behaves as one pixel
        send_pixel(8'h5A, 8'hA5, 8'h3C, 0, 1'b1, 1'b1);
        wait_idle();
        check(frames_done == 3, "R7 zero length", frames_done, 3);

        // R8: short stall mid-frame leaves underrun clear
        send_pixel(8'h0F, 8'hF0, 8'h33, 2, 1'b0, 1'b1);
        repeat (750) @(negedge clk);
        check(s_ready == 1'b1, "R6 ready between pixels", s_ready, 1);
        check(line_out == 1'b0, "R8 line low in stall", line_out, 0);
        send_pixel(8'hCC, 8'h55, 8'h81, 2, 1'b1, 1'b0);
        wait_idle();
        check(underrun == 1'b0, "R8 short stall", underrun, 0);
        check(frames_done == 4, "R7 two-pixel frame", frames_done, 4);

        // R8: long stall raises underrun, held until next frame starts
        send_pixel(8'h01, 8'h02, 8'h04, 2, 1'b0, 1'b1);
        repeat (650 + CLAT + 50) @(negedge clk);
        check(underrun == 1'b1, "R8 long stall", underrun, 1);
        check(line_out == 1'b0, "R8 line low in long stall", line_out, 0);
        check(busy == 1'b1, "R8 frame still open", busy, 1);
        send_pixel(8'h08, 8'h10, 8'h20, 2, 1'b1, 1'b0);
        wait_idle();
        check(underrun == 1'b1, "R8 underrun held", underrun, 1);
        send_pixel(8'hE7, 8'h18, 8'h99, 1, 1'b1, 1'b1);
        check(underrun == 1'b0, "R8 cleared on new frame", underrun, 0);
        wait_idle();
        check(frames_done == 6, "R7 frame total", frames_done, 6);
        check(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150_000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule